// File: doc/BRIEF.md
# GPIO Bank with Interrupt Capture

A bank of 32 general-purpose pins controlled through a small memory-mapped register bus. Software drives pins from an output data register and selects the direction per pin with an output-enable register. It reads the synchronized pin levels from a read-only input register. Every writable register can be written whole, or updated atomically through a set alias and a clear alias that touch only the bits that are 1 in the written mask.

Each pin can raise a sticky status bit. A per-pin mode bit selects level or edge sensing, and a per-pin polarity bit selects high/rising or low/falling. Capture into status is gated by a capture-enable bit. Forwarding of status to the single bank interrupt line is gated by a separate interrupt-enable bit. Software clears status bits by writing ones to the status clear alias.

Address layout: bits [11:8] select the register group (0 output data, 1 input, 2 output enable, 3 capture enable, 4 interrupt enable, 5 level select, 6 polarity, 7 status). Bits [7:4] must match the bank index parameter. Bits [3:2] select the access type (0 plain write, 1 set, 2 clear, 3 no effect). Bits [1:0] are ignored.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, and `pad_out`, `pad_oe` and `irq_out` are zero.
- R2: A write to access type 1 ORs the mask into the register. A write to access type 2 clears the masked bits. Other bits keep their value.
- R3: A write to access type 0 replaces the whole register. A read at any access type returns the register value.
- R4: `pad_out` equals the output data register and `pad_oe` equals the output-enable register (1 = drive the pin).
- R5: The input register (group 1) returns `pad_in` delayed by two clock edges, whatever the direction. Writes to it have no effect.
- R6: With level-select 0, a pin sets its status bit on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The bit is visible three edges after the pad change and stays set after the pad returns.
- R7: With level-select 1, status is set on every cycle that the pin sits at its active level (polarity 1 = high, 0 = low), so a clear does not stick while that level lasts.
- R8: No status bit is set while its capture-enable bit is 0.
- R9: `irq_out` is 1 exactly when some bit is set in both status and interrupt enable.
- R10: Status bits fall only through writes to the status clear alias. Plain and set-alias writes to status have no effect.
- R11: When a clear and a new detection hit the same status bit in one cycle, the bit ends up set.
- R12: Accesses whose bank field differs from the bank index write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address: group, bank, access type |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output data to the pins |
| pad_oe | output | 32 | Per-pin output enable |
| irq_out | output | 1 | Bank interrupt |

## Verification
A corrupted configuration bit shows up at once on `bus_rdata` for its group. For output data and direction it also shows on `pad_out` or `pad_oe` in the same cycle. A wrong synchronizer or previous-value register shifts when status rises. This is visible as a status bit that is already set after two edges, or still clear after three, and it also shows as a second capture where an edge pin should capture only once. A faulty clear or capture gate leaves a status bit set or clear across a read, and `irq_out` follows status in the same cycle. So the fault appears within a few cycles of the triggering stimulus.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared address layout and access encodings for the GPIO bank.
// Assumes a 12-bit byte address with group, bank and access fields.
package gpio_bank_pkg;
    localparam int ADDR_W     = 12;
    localparam int GRP_LSB    = 8;
    localparam int GRP_W      = 4;
    localparam int BANK_LSB   = 4;
    localparam int BANK_W     = 4;
    localparam int ACC_LSB    = 2;
    localparam int NUM_GROUPS = 8;
    localparam int GIDX_W     = $clog2(NUM_GROUPS);

    typedef enum logic [GIDX_W-1:0] {
        GRP_DOUT  = 3'd0,
        GRP_DIN   = 3'd1,
        GRP_OE    = 3'd2,
        GRP_CAPEN = 3'd3,
        GRP_IRQEN = 3'd4,
        GRP_LVL   = 3'd5,
        GRP_POL   = 3'd6,
        GRP_STAT  = 3'd7
    } grp_e;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;
endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
// Address decoder: splits the bus address into group, bank and access type.
// Raises one write strobe per group.
// Assumes bus_wr is a single-cycle pulse. Groups beyond NUM_GROUPS are unmapped.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    output logic [GIDX_W-1:0]      grp_idx,
    output acc_e                   acc,
    output logic                   bank_hit,
    output logic [NUM_GROUPS-1:0]  wr_grp
);
    logic [GRP_W-1:0]  grp_raw;
    logic [BANK_W-1:0] bank_raw;

    // Field extraction from the byte address
    always_comb begin
        grp_raw  = bus_addr[GRP_LSB +: GRP_W];
        bank_raw = bus_addr[BANK_LSB +: BANK_W];
        acc      = acc_e'(bus_addr[ACC_LSB +: 2]);
        grp_idx  = grp_raw[GIDX_W-1:0];
    end

    // Address match: right bank and a mapped group
    always_comb begin
        bank_hit = (bank_raw == BANK_W'(BANK_ID)) && (int'(grp_raw) < NUM_GROUPS);
    end

    // One-hot write strobe for the addressed group
    always_comb begin
        wr_grp = (bus_wr && bank_hit) ? (NUM_GROUPS'(1) << grp_idx) : '0;
    end
endmodule

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
// Configuration register with plain, set-alias and clear-alias writes.
// Assumes wr_en is already qualified by the address decode.
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  acc_e             acc,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Register update: replace, OR in, or mask out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            case (acc)
                ACC_WRITE: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLR:   q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R2
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the asynchronous pad inputs.
// Assumes each pin is a slow level. Bits are not aligned to each other.
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the pads
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    // Remaining stages settle metastability
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Per-pin level/edge detection and the sticky status register.
// Assumes sync_lvl is already synchronized. Detection has priority over clear.
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_lvl,
    input  logic [WIDTH-1:0] cap_en,
    input  logic [WIDTH-1:0] lvl_sel,
    input  logic [WIDTH-1:0] pol_sel,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] stat_q
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] act_now;
    logic [WIDTH-1:0] act_prev;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] clr_vec;
    logic [WIDTH-1:0] lvl_hit;

    // Previous synchronized level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_lvl;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Active-level and detection decision for one pin
        always_comb begin
            act_now[i]  = pol_sel[i] ? sync_lvl[i] : ~sync_lvl[i];
            act_prev[i] = pol_sel[i] ? prev_q[i]   : ~prev_q[i];
            hit[i]      = cap_en[i] & (lvl_sel[i] ? act_now[i]
                                                  : (act_now[i] & ~act_prev[i]));
        end
    end

    // Clear vector from the status clear alias
    always_comb begin
        clr_vec = clr_en ? clr_mask : '0;
        lvl_hit = cap_en & lvl_sel & act_now;
    end

    // Sticky status: new detections override a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | hit;
    end

    AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(cap_en)) == '0)); // R8
    AST_LEVEL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_hit != '0) |=> ((stat_q & $past(lvl_hit)) == $past(lvl_hit))); // R7
    AST_DETECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & hit) != '0) |=> ((stat_q & $past(clr_vec & hit)) == $past(clr_vec & hit))); // R11
    AST_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_vec)) == '0)); // R10
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
// Top of the GPIO bank: address decode, configuration registers,
// input synchronizer, interrupt detection and the bank interrupt line.
// Assumes a single-cycle write strobe. Reads are combinational.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    parameter int BANK_ID     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq_out
);
    logic [GIDX_W-1:0]     grp_idx;
    acc_e                  acc;
    logic                  bank_hit;
    logic [NUM_GROUPS-1:0] wr_grp;
    logic [NUM_PINS-1:0]   regs [NUM_GROUPS];
    logic [NUM_PINS-1:0]   din_sync;
    logic [NUM_PINS-1:0]   stat_q;

    gpio_bank_decode #(.BANK_ID(BANK_ID)) i_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .grp_idx  (grp_idx),
        .acc      (acc),
        .bank_hit (bank_hit),
        .wr_grp   (wr_grp)
    );

    // Writable groups get an alias register; input and status are sourced elsewhere
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_reg
        if (g == int'(GRP_DIN)) begin : g_din
            assign regs[g] = din_sync;
        end else if (g == int'(GRP_STAT)) begin : g_stat
            assign regs[g] = stat_q;
        end else begin : g_cfg
            gpio_alias_reg #(.WIDTH(NUM_PINS)) i_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_grp[g]),
                .acc   (acc),
                .wdata (bus_wdata),
                .q     (regs[g])
            );
        end
    end

    gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_irq_detect #(.WIDTH(NUM_PINS)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (din_sync),
        .cap_en   (regs[GRP_CAPEN]),
        .lvl_sel  (regs[GRP_LVL]),
        .pol_sel  (regs[GRP_POL]),
        .clr_en   (wr_grp[GRP_STAT] && (acc == ACC_CLR)),
        .clr_mask (bus_wdata),
        .stat_q   (stat_q)
    );

    // Read mux and pin/interrupt outputs
    always_comb begin
        bus_rdata = bank_hit ? regs[grp_idx] : '0;
        pad_out   = regs[GRP_DOUT];
        pad_oe    = regs[GRP_OE];
        irq_out   = |(stat_q & regs[GRP_IRQEN]);
    end
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // Group codes (address bits [11:8]) and access codes (bits [3:2])
    localparam logic [3:0] G_DOUT = 4'd0, G_DIN = 4'd1, G_OE = 4'd2, G_CAP = 4'd3,
                           G_IEN = 4'd4, G_LVL = 4'd5, G_POL = 4'd6, G_STAT = 4'd7;
    localparam logic [1:0] A_WR = 2'd0, A_SET = 2'd1, A_CLR = 2'd2;

    function automatic logic [11:0] adr(input logic [3:0] g, input logic [1:0] a,
                                        input logic [3:0] bank = 4'd0);
        return {g, bank, a, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        for (int g = 0; g < 8; g++) begin
            rd(adr(4'(g), A_WR), v);
            chk("R1 register reset", v, '0);
        end
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq_out", {31'b0, irq_out}, '0);
    endtask

    task automatic t_alias();
        logic [W-1:0] v;
        wr(adr(G_DOUT, A_WR), 32'hA5A5_0F0F);
        rd(adr(G_DOUT, A_SET), v);
        chk("R3 plain write", v, 32'hA5A5_0F0F);
        chk("R4 pad_out", pad_out, 32'hA5A5_0F0F);
        wr(adr(G_DOUT, A_SET), 32'h0000_F000);
        rd(adr(G_DOUT, A_WR), v);
        chk("R2 set alias", v, 32'hA5A5_FF0F);
        wr(adr(G_DOUT, A_CLR), 32'hA000_000F);
        rd(adr(G_DOUT, A_CLR), v);
        chk("R2 clear alias", v, 32'h05A5_FF00);
        wr(adr(G_OE, A_SET), 32'hFFFF_0000);
        chk("R4 pad_oe", pad_oe, 32'hFFFF_0000);
        wr(adr(G_OE, A_CLR), 32'h00FF_0000);
        chk("R4 pad_oe after clear", pad_oe, 32'hFF00_0000);
    endtask

    task automatic t_input();
        logic [W-1:0] v;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(posedge clk);
        @(negedge clk);
        rd(adr(G_DIN, A_WR), v);
        chk("R5 input after one edge", v, '0);
        @(posedge clk);
        @(negedge clk);
        rd(adr(G_DIN, A_WR), v);
        chk("R5 input after two edges", v, 32'h1234_5678);
        wr(adr(G_DIN, A_WR), 32'hFFFF_FFFF);
        rd(adr(G_DIN, A_WR), v);
        chk("R5 input write ignored", v, 32'h1234_5678);
        pad_in = '0;
        cycles(4);
    endtask

    task automatic t_edge();
        logic [W-1:0] v;
        wr(adr(G_POL, A_SET), 32'h1);      // pin0 rising, pin1 falling
        wr(adr(G_CAP, A_SET), 32'h3);
        @(negedge clk);
        pad_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 status not yet set at two edges", v, '0);
        @(posedge clk);
        @(negedge clk);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 rising edge captured at three edges", v, 32'h1);
        pad_in[0] = 1'b0;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 status sticky", v, 32'h1);
        wr(adr(G_STAT, A_CLR), 32'h1);
        cycles(3);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 edge does not re-arm", v, '0);
        pad_in[1] = 1'b1;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 rising ignored on falling pin", v, '0);
        pad_in[1] = 1'b0;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R6 falling edge captured", v, 32'h2);
        wr(adr(G_CAP, A_CLR), 32'h3);
        wr(adr(G_STAT, A_CLR), 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [W-1:0] v;
        wr(adr(G_POL, A_SET), 32'h10);
        wr(adr(G_LVL, A_SET), 32'h10);
        wr(adr(G_CAP, A_SET), 32'h10);
        pad_in[4] = 1'b1;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R7 high level captured", v, 32'h10);
        wr(adr(G_STAT, A_CLR), 32'h10);
        rd(adr(G_STAT, A_WR), v);
        chk("R11 detection beats clear", v, 32'h10);
        pad_in[4] = 1'b0;
        cycles(4);
        wr(adr(G_STAT, A_CLR), 32'h10);
        rd(adr(G_STAT, A_WR), v);
        chk("R7 clear holds once level gone", v, '0);
        wr(adr(G_LVL, A_SET), 32'h20);
        wr(adr(G_CAP, A_SET), 32'h20);
        cycles(1);
        rd(adr(G_STAT, A_WR), v);
        chk("R7 low level captured", v, 32'h20);
        wr(adr(G_CAP, A_CLR), 32'h30);
        wr(adr(G_STAT, A_CLR), 32'hFFFF_FFFF);
        rd(adr(G_STAT, A_WR), v);
        chk("R7 status cleared after disable", v, '0);
    endtask

    task automatic t_capgate();
        logic [W-1:0] v;
        wr(adr(G_POL, A_SET), 32'h300);    // pin8 rising edge, pin9 high level
        wr(adr(G_LVL, A_SET), 32'h200);
        pad_in[8] = 1'b1; pad_in[9] = 1'b1;
        cycles(4);
        pad_in[8] = 1'b0;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R8 no capture without enable", v, '0);
        pad_in[9] = 1'b0;
        cycles(3);
    endtask

    task automatic t_irq();
        logic [W-1:0] v;
        wr(adr(G_POL, A_SET), 32'h1000);
        wr(adr(G_CAP, A_SET), 32'h1000);
        pad_in[12] = 1'b1;
        cycles(4);
        rd(adr(G_STAT, A_WR), v);
        chk("R9 status set", v, 32'h1000);
        chk("R9 irq low without enable", {31'b0, irq_out}, '0);
        wr(adr(G_IEN, A_SET), 32'h1000);
        chk("R9 irq high with enable", {31'b0, irq_out}, 32'h1);
        wr(adr(G_IEN, A_WR), 32'h2000);
        chk("R9 irq low with other pin enabled", {31'b0, irq_out}, '0);
        wr(adr(G_IEN, A_WR), 32'h1000);
        wr(adr(G_STAT, A_WR), 32'h0);
        rd(adr(G_STAT, A_WR), v);
        chk("R10 plain write to status ignored", v, 32'h1000);
        wr(adr(G_STAT, A_SET), 32'h0000_FFFF);
        rd(adr(G_STAT, A_WR), v);
        chk("R10 set alias on status ignored", v, 32'h1000);
        chk("R9 irq still high", {31'b0, irq_out}, 32'h1);
        wr(adr(G_STAT, A_CLR), 32'h1000);
        rd(adr(G_STAT, A_WR), v);
        chk("R10 clear alias clears", v, '0);
        chk("R9 irq low after clear", {31'b0, irq_out}, '0);
    endtask

    task automatic t_bank();
        logic [W-1:0] v;
        wr(adr(G_DOUT, A_WR, 4'd1), 32'hDEAD_BEEF);
        chk("R12 foreign bank write ignored", pad_out, 32'h05A5_FF00);
        rd(adr(G_DOUT, A_WR, 4'd1), v);
        chk("R12 foreign bank reads zero", v, '0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias();
        t_input();
        t_edge();
        t_level();
        t_capgate();
        t_irq();
        t_bank();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule